// File: doc/BRIEF.md
# Dual-Output PWM Cycle Generator with Locked Set Update

The block produces two pulse-width-modulated outputs from one free-running 12-bit cycle counter. Each output has a set compare value and a reset compare value. The reset value of output 1 also sets the cycle length. Software loads new compare values, output polarity and a mode bit into staging registers through a simple write port. These values only reach the active registers as one group, at the edge that closes a PWM cycle. As a result, every cycle runs with a single coherent set of values.

Two control bits decide when that group transfer happens:
- **Lock:** holds the staged set back for as long as it is set.
- **Auto-lock:** makes the transfer depend on which staging register was written last. Auto-lock overrides lock.

A run input stops the generator so that new values can be applied at once, and restarts it at count zero. In fifty-percent mode, output 0 takes its timing from output 1's compare values. A one-clock end-of-cycle pulse and a pending flag let software follow the updates.

Top module: `pwm_pair_sync`

## Requirements
- R1: The active set (four compare values, polarity bits and the mode bit) changes only at a clock edge where the cycle ends or where the generator is stopped, and all of its fields change together.
- R2: While running, the counter steps 0, 1, … up to the active output-1 reset value and then returns to 0. `cycle_end` is high during exactly the clock in which the count equals that value.
- R3: `pwm0` is high while the count lies in the circular window that starts at the set value and ends before the reset value. The window is empty when the two values are equal. `pwm1` works the same way with its own pair. Active polarity bit 0 inverts `pwm0`, and bit 1 inverts `pwm1`.
- R4: With lock and auto-lock both clear, any staging write is transferred at the next end of cycle. `upd_pending` rises on the clock after a staging write and clears on the clock after the transfer.
- R5: While lock is 1 and the effective auto-lock is 0, no transfer occurs, whatever is written.
- R6: Once lock is written back to 0, a pending staged set is transferred at the end of the cycle in progress.
- R7: With auto-lock in effect, a transfer happens at the end of a cycle only if output 1's reset value was the last staging register written. Any later write to another staging register cancels that trigger.
- R8: A write to the auto-lock bit takes effect at the first end of cycle after the write. That end of cycle is still governed by the previous setting.
- R9: When auto-lock and lock are both 1, the auto-lock rule decides the transfer.
- R10: When the staged mode bit is 1 at transfer time, output 0's active set and reset values are loaded from output 1's staged pair, so the two outputs are identical.
- R11: After reset all outputs are 0 and all active values are 0. While `run` is 0, the counter is held at 0, both PWM outputs and `cycle_end` are 0, and every clock acts as an end of cycle for transfers. When `run` returns to 1, counting starts at 0.
- R12: A staging write in the same clock as a transfer edge is not part of that transfer. It stays pending for the next end of cycle.
- R13: Write port map (`wr_addr`):
  - 0: output 0 set value
  - 1: output 0 reset value
  - 2: output 1 set value
  - 3: output 1 reset value
  - 4: configuration — bit 0 and bit 1 are the polarity bits, bit 2 is the mode bit
  - 5: control — bit 0 is lock, bit 1 is auto-lock

  Addresses 0 to 4 are staging registers; address 5 is not staged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | 1 runs the cycle counter, 0 stops and clears it |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 12 | Register write data |
| pwm0 | output | 1 | PWM output 0 |
| pwm1 | output | 1 | PWM output 1 |
| cycle_end | output | 1 | One-clock pulse in the last count of a cycle |
| upd_pending | output | 1 | Staged values wait for transfer |

## Verification
Two events can land in the same clock: a staging write and the group transfer at end of cycle. The bench provokes this by tracking the count in its own model and placing a write exactly in the clock where the count equals the active cycle length. The scoreboard then expects the old set to be committed, with `upd_pending` still high afterwards, and the written value to take effect only one cycle later. Lock release, auto-lock arming and stop/restart are each provoked mid-cycle, and the outputs are judged cycle by cycle against the model's expected waveform.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
    localparam int CW     = 12;
    localparam int AW     = 3;

    localparam logic [AW-1:0] A_SA  = 3'd0;
    localparam logic [AW-1:0] A_RA  = 3'd1;
    localparam logic [AW-1:0] A_SB  = 3'd2;
    localparam logic [AW-1:0] A_RB  = 3'd3;
    localparam logic [AW-1:0] A_CFG = 3'd4;
    localparam logic [AW-1:0] A_CTL = 3'd5;

    typedef struct packed {
        logic [CW-1:0] sa;
        logic [CW-1:0] ra;
        logic [CW-1:0] sb;
        logic [CW-1:0] rb;
        logic [1:0]    pol;
        logic          fifty;
    } tset_t;
endpackage

// File: rtl/pwm_stage_bank.sv
module pwm_stage_bank
    import pwm_pair_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic          commit_i,
    output tset_t         stg_o,
    output logic          pend_o,
    output logic          rb_last_o,
    output logic          lock_o,
    output logic          auto_req_o
);
    typedef struct packed {
        tset_t stg;
        logic  pend;
        logic  rb_last;
        logic  lock;
        logic  auto_req;
    } bank_t;

    bank_t d, q;

    always_comb begin
        d = q;
        if (commit_i) begin
            d.pend    = 1'b0;
            d.rb_last = 1'b0;
        end
        if (wr_en) begin
            if (wr_addr <= A_CFG) begin
                d.pend    = 1'b1;
                d.rb_last = (wr_addr == A_RB);
            end
            case (wr_addr)
                A_SA:    d.stg.sa = wr_data;
                A_RA:    d.stg.ra = wr_data;
                A_SB:    d.stg.sb = wr_data;
                A_RB:    d.stg.rb = wr_data;
                A_CFG: begin
                    d.stg.pol   = wr_data[1:0];
                    d.stg.fifty = wr_data[2];
                end
                A_CTL: begin
                    d.lock     = wr_data[0];
                    d.auto_req = wr_data[1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign stg_o      = q.stg;
    assign pend_o     = q.pend;
    assign rb_last_o  = q.rb_last;
    assign lock_o     = q.lock;
    assign auto_req_o = q.auto_req;

    // R7
    rb_last_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.rb_last |-> q.pend);
endmodule

// File: rtl/pwm_commit_ctrl.sv
module pwm_commit_ctrl
    import pwm_pair_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  strobe_i,
    input  tset_t stg_i,
    input  logic  pend_i,
    input  logic  rb_last_i,
    input  logic  lock_i,
    input  logic  auto_req_i,
    output logic  commit_o,
    output tset_t act_o
);
    typedef struct packed {
        tset_t act;
        logic  auto_eff;
    } ctl_t;

    ctl_t d, q;
    logic go;

    always_comb begin
        go = strobe_i && (q.auto_eff ? rb_last_i : (pend_i && !lock_i));
        d  = q;
        if (go) begin
            d.act = stg_i;
            if (stg_i.fifty) begin
                d.act.sa = stg_i.sb;
                d.act.ra = stg_i.rb;
            end
        end
        if (strobe_i) d.auto_eff = auto_req_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign commit_o = go;
    assign act_o    = q.act;

    // R5
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.auto_eff && lock_i) |=> $stable(q.act));
    // R10
    fifty_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.act.fifty |-> (q.act.sa == q.act.sb && q.act.ra == q.act.rb));
    // R8
    auto_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |=> $stable(q.auto_eff));
endmodule

// File: rtl/pwm_wave_gen.sv
module pwm_wave_gen
    import pwm_pair_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  tset_t      act_i,
    output logic       eoc_o,
    output logic [1:0] out_o
);
    localparam int NCH = 2;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        eoc_o = run_i && (cnt_q == act_i.rb);
        cnt_d = (!run_i || eoc_o) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [CW-1:0] s_v, r_v;
        logic          win;
        assign s_v = (ch == 0) ? act_i.sa : act_i.sb;
        assign r_v = (ch == 0) ? act_i.ra : act_i.rb;
        always_comb begin
            if (s_v < r_v)      win = (cnt_q >= s_v) && (cnt_q < r_v);
            else if (s_v > r_v) win = (cnt_q >= s_v) || (cnt_q < r_v);
            else                win = 1'b0;
        end
        assign out_o[ch] = run_i && (win ^ act_i.pol[ch]);
    end

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= act_i.rb);
    // R2
    eoc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_o |=> (!eoc_o || act_i.rb == '0));
    // R11
    stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> cnt_q == '0);
endmodule

// File: rtl/pwm_pair_sync.sv
module pwm_pair_sync
    import pwm_pair_pkg::*;
#(
    parameter int CNT_W  = CW,
    parameter int ADDR_W = AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic              pwm0,
    output logic              pwm1,
    output logic              cycle_end,
    output logic              upd_pending
);
    tset_t      stg_w, act_w;
    logic       pend_w, rb_last_w, lock_w, auto_req_w;
    logic       commit_w, eoc_w;
    logic [1:0] out_w;

    pwm_stage_bank u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .commit_i(commit_w), .stg_o(stg_w),
        .pend_o(pend_w), .rb_last_o(rb_last_w), .lock_o(lock_w),
        .auto_req_o(auto_req_w)
    );

    pwm_commit_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .strobe_i(eoc_w || !run), .stg_i(stg_w),
        .pend_i(pend_w), .rb_last_i(rb_last_w), .lock_i(lock_w),
        .auto_req_i(auto_req_w), .commit_o(commit_w), .act_o(act_w)
    );

    pwm_wave_gen u_wave (
        .clk(clk), .rst_n(rst_n), .run_i(run), .act_i(act_w),
        .eoc_o(eoc_w), .out_o(out_w)
    );

    assign pwm0        = out_w[0];
    assign pwm1        = out_w[1];
    assign cycle_end   = eoc_w;
    assign upd_pending = pend_w;

    // R1
    commit_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_w) |-> $past(eoc_w || !run));
    // R4
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_w && !(wr_en && wr_addr <= A_CFG)) |=> !upd_pending);
endmodule

// File: tb/sim_pwm_pair_sync.sv
module sim_pwm_pair_sync;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [11:0] wr_data = '0;
    logic        pwm0, pwm1, cycle_end, upd_pending;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pwm_pair_sync u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pwm0(pwm0), .pwm1(pwm1),
        .cycle_end(cycle_end), .upd_pending(upd_pending)
    );

    // model state
    logic [11:0] m_stg [4];
    logic [11:0] m_act [4];
    logic [1:0]  m_spol, m_apol;
    logic        m_sfifty;
    logic        m_lock, m_areq, m_aeff, m_pend, m_lrb;
    logic [11:0] m_cnt;

    logic [3:0] exp_q [$];
    string      tag_q [$];

    function automatic logic win(input logic [11:0] c, s, r);
        if (s < r)      return (c >= s) && (c < r);
        else if (s > r) return (c >= s) || (c < r);
        else            return 1'b0;
    endfunction

    task automatic cyc(input logic r, input logic we, input logic [2:0] a,
                       input logic [11:0] dat, input string tag);
        logic [3:0] e;
        logic strobe, commit;
        @(negedge clk);
        run = r; wr_en = we; wr_addr = a; wr_data = dat;
        #1;
        e[3] = r && (m_cnt == m_act[3]);
        e[2] = r && (win(m_cnt, m_act[2], m_act[3]) ^ m_apol[1]);
        e[1] = r && (win(m_cnt, m_act[0], m_act[1]) ^ m_apol[0]);
        e[0] = m_pend;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(posedge clk);
        strobe = !r || (m_cnt == m_act[3]);
        commit = strobe && (m_aeff ? m_lrb : (m_pend && !m_lock));
        m_cnt  = strobe ? 12'd0 : m_cnt + 12'd1;
        if (commit) begin
            for (int i = 0; i < 4; i++) m_act[i] = m_stg[i];
            if (m_sfifty) begin
                m_act[0] = m_stg[2];
                m_act[1] = m_stg[3];
            end
            m_apol = m_spol;
            m_pend = 1'b0;
            m_lrb  = 1'b0;
        end
        if (strobe) m_aeff = m_areq;
        if (we) begin
            if (a <= 3'd4) begin
                m_pend = 1'b1;
                m_lrb  = (a == 3'd3);
            end
            if (a <= 3'd3) m_stg[a[1:0]] = dat;
            else if (a == 3'd4) begin
                m_spol = dat[1:0]; m_sfifty = dat[2];
            end else if (a == 3'd5) begin
                m_lock = dat[0]; m_areq = dat[1];
            end
        end
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 3'd0, 12'd0, tag);
    endtask

    task automatic wr(input logic [2:0] a, input logic [11:0] dat, input string tag);
        cyc(run, 1'b1, a, dat, tag);
    endtask

    task automatic wr_at_eoc(input logic [2:0] a, input logic [11:0] dat, input string tag);
        while (m_cnt != m_act[3]) cyc(1'b1, 1'b0, 3'd0, 12'd0, tag);
        cyc(1'b1, 1'b1, a, dat, tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (exp_q.size() > 0) begin
                logic [3:0] e, act;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                act = {cycle_end, pwm1, pwm0, upd_pending};
                checks++;
                if (act !== e) begin
                    errors++;
                    $display("FAIL %s: {eoc,pwm1,pwm0,pend} actual=%b expected=%b at %0t",
                             t, act, e, $time);
                end
            end
        end
    end

    // watchdog
    initial begin
        #1_500_000;
        errors++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_stg[i] = '0; m_act[i] = '0; end
        m_spol = '0; m_apol = '0; m_sfifty = 0;
        m_lock = 0; m_areq = 0; m_aeff = 0; m_pend = 0; m_lrb = 0; m_cnt = '0;

        // R11 reset state
        #23;
        checks++;
        if ({cycle_end, pwm1, pwm0, upd_pending} !== 4'b0) begin
            errors++;
            $display("FAIL R11 reset: actual=%b expected=0000",
                     {cycle_end, pwm1, pwm0, upd_pending});
        end
        @(negedge clk); rst_n = 1'b1;

        // R11 / R13: load while stopped, transfer while stopped
        cyc(0, 0, 0, 0, "R11");
        cyc(0, 1, 3'd0, 12'd2, "R13");
        cyc(0, 1, 3'd1, 12'd6, "R13");
        cyc(0, 1, 3'd2, 12'd4, "R13");
        cyc(0, 1, 3'd3, 12'd9, "R13");
        cyc(0, 0, 0, 0, "R11");
        cyc(0, 0, 0, 0, "R11");
        // R2 / R3 basic waveform
        idle(30, "R2");
        // R4 unlocked update mid-cycle
        idle(3, "R4");
        wr(3'd1, 12'd3, "R4");
        idle(25, "R3");
        // R5 lock holds
        wr(3'd5, 12'd1, "R5");
        wr(3'd2, 12'd1, "R5");
        wr(3'd3, 12'd7, "R5");
        idle(30, "R5");
        // R6 release
        wr(3'd5, 12'd0, "R6");
        idle(25, "R6");
        // R3 polarity and wrap window
        wr(3'd4, 12'd3, "R3");
        idle(20, "R3");
        wr(3'd0, 12'd5, "R3");
        wr(3'd1, 12'd2, "R3");
        wr(3'd4, 12'd0, "R3");
        idle(20, "R3");
        // R8 autolock arming uses old rule at first end of cycle
        idle(2, "R8");
        wr(3'd0, 12'd1, "R8");
        wr(3'd5, 12'd2, "R8");
        idle(20, "R8");
        // R7 last write not RB: no transfer
        wr(3'd3, 12'd8, "R7");
        wr(3'd0, 12'd0, "R7");
        idle(25, "R7");
        // R7 last write RB: transfer
        wr(3'd3, 12'd8, "R7");
        idle(22, "R7");
        // R9 autolock beats lock
        wr(3'd5, 12'd3, "R9");
        wr(3'd2, 12'd2, "R9");
        wr(3'd3, 12'd6, "R9");
        idle(20, "R9");
        // back to plain mode
        wr(3'd5, 12'd0, "R8");
        idle(16, "R8");
        // R10 fifty mode
        wr(3'd4, 12'd4, "R10");
        wr(3'd2, 12'd1, "R10");
        idle(25, "R10");
        wr(3'd4, 12'd0, "R10");
        idle(16, "R10");
        // R12 write colliding with end of cycle
        wr_at_eoc(3'd1, 12'd4, "R12");
        idle(25, "R12");
        wr_at_eoc(3'd3, 12'd5, "R12");
        idle(25, "R12");
        // R11 stop mid-cycle, apply, restart
        idle(3, "R11");
        cyc(0, 0, 0, 0, "R11");
        cyc(0, 1, 3'd3, 12'd4, "R11");
        cyc(0, 0, 0, 0, "R11");
        cyc(0, 0, 0, 0, "R11");
        idle(20, "R11");

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule